// File: doc/BRIEF.md
# Scannable Return-State Stack Register

This block is the storage half of a controller that can call a shared sequence of states and then come back, much like a subroutine call. External next-state logic gives it three things: the next state, a return state, and a two-bit stack command. On every falling clock edge the block loads the state register and updates a small stack of saved return states at the same time. The top entry of that stack is an output, so the external logic can pick it as the next state when a called sequence ends.

The stack never overflows or underflows. A push that finds the stack full drops the deepest entry. A pop copies the deepest entry into the slot above it and leaves the deepest entry unchanged. When test mode is on, the state register and every stack entry form one serial scan chain. The chain shifts one bit per falling edge and all functional updates stop.

Top module: `ret_stack_reg`

## Requirements
- R1: When reset and test mode are both low, each falling clock edge loads `next_state` into `cur_state`. Registers do not change on the rising edge.
- R2: Command code 2'b01 (push) moves every stack entry one position deeper and discards the deepest entry. The top entry loads `ret_state`.
- R3: Command code 2'b10 (pop) moves every entry one position toward the top. The deepest entry keeps its value, so after enough pops every entry equals the old deepest value.
- R4: Command codes 2'b00 and 2'b11 leave every stack entry unchanged. `ret_state` has no effect under any command except push.
- R5: Reset is synchronous and is sampled at the falling edge. While it is high, that edge loads 0 into the state register and into every stack entry. Reset takes priority over test mode and over the command.
- R6: While `test_en` is high and reset is low, each falling edge shifts the chain by one bit, and `next_state`, `ret_state` and the command are ignored. The chain order is: `scan_in`, then the state bits from LSB to MSB, then each stack entry from LSB to MSB, going from the top entry down to the deepest.
- R7: `scan_out` always equals the MSB of the deepest stack entry.
- R8: `stack_top` comes straight from the top register. A value pushed at a falling edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| stk_cmd | input | 2 | Stack command: 00 hold, 01 push, 10 pop, 11 hold |
| next_state | input | STATE_W | State loaded at the next falling edge |
| ret_state | input | STATE_W | Return state stored on a push |
| test_en | input | 1 | Scan mode enable |
| scan_in | input | 1 | Serial scan data in |
| cur_state | output | STATE_W | Current state register |
| stack_top | output | STATE_W | Top stack entry |
| scan_out | output | 1 | Serial scan data out (MSB of deepest entry) |

## Verification
The deepest stack entry cannot be read directly at the ports. Its effects are hard to see: the value a full push throws away, and the value a pop copies upward. The stimulus fills the stack past its depth and then pops repeatedly, so the deepest entry rises to `stack_top`. The bench also loads a known state and known stack contents through functional pushes, shifts the whole chain out through `scan_out` while shifting a new image in, and confirms the new image at `cur_state` and `stack_top` and with a pop afterwards.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_PUSH  = 2'b01,
        CMD_POP   = 2'b10,
        CMD_HOLD2 = 2'b11
    } stk_cmd_e;

endpackage

// File: rtl/rsr_stack_next.sv
// Computes the next stack contents from the command; entry 0 is the top.
module rsr_stack_next
    import rsr_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int DEPTH   = 2
) (
    input  stk_cmd_e                       cmd,
    input  logic [STATE_W-1:0]             ret_state,
    input  logic [DEPTH-1:0][STATE_W-1:0]  stk_q,
    output logic [DEPTH-1:0][STATE_W-1:0]  stk_d
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [STATE_W-1:0] from_above;
        logic [STATE_W-1:0] from_below;

        if (i == 0) begin : g_top
            assign from_above = ret_state;
        end else begin : g_inner_a
            assign from_above = stk_q[i-1];
        end

        if (i == DEPTH-1) begin : g_bottom
            assign from_below = stk_q[i];      // deepest keeps its value on pop
        end else begin : g_inner_b
            assign from_below = stk_q[i+1];
        end

        always_comb begin
            unique case (cmd)
                CMD_PUSH: stk_d[i] = from_above;
                CMD_POP:  stk_d[i] = from_below;
                default:  stk_d[i] = stk_q[i];
            endcase
        end
    end

endmodule

// File: rtl/rsr_scan_shift.sv
// One-bit shift of the serial chain; bit 0 takes the scan input.
module rsr_scan_shift #(
    parameter int LEN = 9
) (
    input  logic [LEN-1:0] chain_q,
    input  logic           scan_in,
    output logic [LEN-1:0] chain_d
);

    assign chain_d = {chain_q[LEN-2:0], scan_in};

endmodule

// File: rtl/ret_stack_reg.sv
module ret_stack_reg
    import rsr_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int DEPTH   = 2   // must be at least 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         stk_cmd,
    input  logic [STATE_W-1:0] next_state,
    input  logic [STATE_W-1:0] ret_state,
    input  logic               test_en,
    input  logic               scan_in,
    output logic [STATE_W-1:0] cur_state,
    output logic [STATE_W-1:0] stack_top,
    output logic               scan_out
);

    localparam int STK_BITS  = STATE_W * DEPTH;
    localparam int CHAIN_LEN = STK_BITS + STATE_W;

    // Packed so that the bit order is the scan order: state at the LSBs,
    // then the top entry, with the deepest entry at the MSBs.
    typedef struct packed {
        logic [DEPTH-1:0][STATE_W-1:0] stk;
        logic [STATE_W-1:0]            state;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [DEPTH-1:0][STATE_W-1:0] stk_func_d;
    logic [CHAIN_LEN-1:0]          chain_shift_d;
    logic [STK_BITS-1:0]           stk_flat;

    rsr_stack_next #(
        .STATE_W (STATE_W),
        .DEPTH   (DEPTH)
    ) u_stack_next (
        .cmd       (stk_cmd_e'(stk_cmd)),
        .ret_state (ret_state),
        .stk_q     (regs_q.stk),
        .stk_d     (stk_func_d)
    );

    rsr_scan_shift #(
        .LEN (CHAIN_LEN)
    ) u_scan_shift (
        .chain_q (regs_q),
        .scan_in (scan_in),
        .chain_d (chain_shift_d)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else if (test_en) begin
            regs_d = regs_t'(chain_shift_d);
        end else begin
            regs_d.state = next_state;
            regs_d.stk   = stk_func_d;
        end
    end

    always_ff @(negedge clk) begin
        regs_q <= regs_d;
    end

    assign stk_flat  = regs_q.stk;
    assign cur_state = regs_q.state;
    assign stack_top = regs_q.stk[0];
    assign scan_out  = regs_q.stk[DEPTH-1][STATE_W-1];

endmodule

// File: rtl/rsr_checker.sv
module rsr_checker #(
    parameter int STATE_W = 3,
    parameter int DEPTH   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 stk_cmd,
    input logic [STATE_W-1:0]         next_state,
    input logic [STATE_W-1:0]         ret_state,
    input logic                       test_en,
    input logic                       scan_in,
    input logic [STATE_W-1:0]         cur_state,
    input logic [STATE_W-1:0]         stack_top,
    input logic [STATE_W*DEPTH-1:0]   stk_flat
);

    assert_state_load_R1: assert property (@(negedge clk) disable iff (rst)
        !test_en |=> cur_state == $past(next_state));

    assert_push_top_R2: assert property (@(negedge clk) disable iff (rst)
        (!test_en && stk_cmd == 2'b01) |=> stack_top == $past(ret_state));

    assert_hold_stack_R4: assert property (@(negedge clk) disable iff (rst)
        (!test_en && (stk_cmd == 2'b00 || stk_cmd == 2'b11)) |=> $stable(stk_flat));

    assert_reset_clear_R5: assert property (@(negedge clk)
        rst |=> (cur_state == '0 && stk_flat == '0));

    assert_scan_entry_R6: assert property (@(negedge clk) disable iff (rst)
        test_en |=> cur_state[0] == $past(scan_in));

    if (DEPTH > 1) begin : g_pop
        assert_pop_rise_R3: assert property (@(negedge clk) disable iff (rst)
            (!test_en && stk_cmd == 2'b10) |=> stack_top == $past(stk_flat[2*STATE_W-1:STATE_W]));
    end

endmodule

bind ret_stack_reg rsr_checker #(
    .STATE_W (STATE_W),
    .DEPTH   (DEPTH)
) u_rsr_checker (
    .clk        (clk),
    .rst        (rst),
    .stk_cmd    (stk_cmd),
    .next_state (next_state),
    .ret_state  (ret_state),
    .test_en    (test_en),
    .scan_in    (scan_in),
    .cur_state  (cur_state),
    .stack_top  (stack_top),
    .stk_flat   (stk_flat)
);

// File: tb/ret_stack_reg_bench.sv
`timescale 1ns/1ps
module ret_stack_reg_bench;

    localparam int W = 3;
    localparam int D = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   stk_cmd = 2'b00;
    logic [W-1:0] next_state = '0;
    logic [W-1:0] ret_state = '0;
    logic         test_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [W-1:0] cur_state;
    logic [W-1:0] stack_top;
    logic         scan_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    ret_stack_reg #(.STATE_W(W), .DEPTH(D)) u_ret_stack_reg (
        .clk(clk), .rst(rst), .stk_cmd(stk_cmd), .next_state(next_state),
        .ret_state(ret_state), .test_en(test_en), .scan_in(scan_in),
        .cur_state(cur_state), .stack_top(stack_top), .scan_out(scan_out)
    );

    typedef struct packed {
        logic         rst;
        logic [1:0]   cmd;
        logic [W-1:0] nxt;
        logic [W-1:0] ret;
        logic [W-1:0] e_state;
        logic [W-1:0] e_top;
    } vec_t;

    // cmd: 00 hold, 01 push, 10 pop, 11 hold
    localparam vec_t VEC [12] = '{
        '{1'b1, 2'b01, 3'd5, 3'd3, 3'd0, 3'd0},  // R5 reset beats push
        '{1'b0, 2'b01, 3'd1, 3'd5, 3'd1, 3'd5},  // R2 push -> [5,0]
        '{1'b0, 2'b00, 3'd2, 3'd7, 3'd2, 3'd5},  // R4 hold, ret ignored
        '{1'b0, 2'b01, 3'd4, 3'd6, 3'd4, 3'd6},  // R2 push -> [6,5]
        '{1'b0, 2'b01, 3'd3, 3'd2, 3'd3, 3'd2},  // R2 full push drops 5 -> [2,6]
        '{1'b0, 2'b10, 3'd2, 3'd7, 3'd2, 3'd6},  // R3 pop -> [6,6]
        '{1'b0, 2'b10, 3'd5, 3'd1, 3'd5, 3'd6},  // R3 pop duplicates bottom
        '{1'b0, 2'b11, 3'd0, 3'd4, 3'd0, 3'd6},  // R4 code 11 holds
        '{1'b0, 2'b01, 3'd7, 3'd1, 3'd7, 3'd1},  // R8 push visible at once
        '{1'b0, 2'b10, 3'd6, 3'd0, 3'd6, 3'd6},  // R3 pop -> [6,6]
        '{1'b1, 2'b00, 3'd3, 3'd3, 3'd0, 3'd0},  // R5 reset clears stack
        '{1'b0, 2'b10, 3'd1, 3'd2, 3'd1, 3'd0}   // R5 bottom was cleared
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic r, logic [1:0] c, logic [W-1:0] n, logic [W-1:0] rv);
        rst = r; stk_cmd = c; next_state = n; ret_state = rv;
        @(negedge clk); #5;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [8:0] old_img;
        logic [8:0] new_img;
        logic [17:0] stream;
        logic [W-1:0] prev_state;

        @(negedge clk); @(negedge clk); #5;
        check("R5 reset state", cur_state, 0);
        check("R5 reset top", stack_top, 0);
        check("R7 reset scan_out", scan_out, 0);

        prev_state = cur_state;
        for (int k = 0; k < 12; k++) begin
            rst = VEC[k].rst; stk_cmd = VEC[k].cmd;
            next_state = VEC[k].nxt; ret_state = VEC[k].ret;
            @(posedge clk); #2;
            check("R1 no rising update", cur_state, prev_state);
            @(negedge clk); #5;
            check($sformatf("R1 state vec%0d", k), cur_state, VEC[k].e_state);
            check($sformatf("R2/R3/R4 top vec%0d", k), stack_top, VEC[k].e_top);
            prev_state = cur_state;
        end

        // Build state 3, stack [6,5] functionally
        apply(1'b0, 2'b01, 3'd0, 3'd5);
        apply(1'b0, 2'b01, 3'd3, 3'd6);
        check("R8 top after push", stack_top, 6);
        check("R7 scan_out is bottom MSB", scan_out, 1);

        old_img = {3'd5, 3'd6, 3'd3};
        new_img = {3'd2, 3'd1, 3'd4};
        stream  = {old_img, new_img};
        test_en = 1'b1;
        rst = 1'b0; stk_cmd = 2'b01; next_state = 3'd7; ret_state = 3'd7;
        for (int j = 0; j < 9; j++) begin
            scan_in = new_img[8-j];
            @(negedge clk); #5;
            check($sformatf("R6 scan_out shift%0d", j), scan_out, stream[17-(j+1)]);
            if (j == 0)
                check("R6 functional load suppressed", cur_state, 6);
        end
        test_en = 1'b0;
        check("R6 scanned state", cur_state, 4);
        check("R6 scanned top", stack_top, 1);
        apply(1'b0, 2'b10, 3'd0, 3'd0);
        check("R3 pop brings scanned bottom", stack_top, 2);
        check("R7 scan_out after pop", scan_out, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule